// File: doc/BRIEF.md
# Timer/Counter with Compare-Match Waveform Output

An 8-bit timer that advances on a one-cycle count-enable tick, compares its count against a single compare register and drives one output pin from a 2-bit action field whenever the two are equal. A mode field picks between a free-running counter that wraps at its all-ones value and a clear-on-compare counter whose period is set by the compare register. Software-style write ports load the count, the compare value, the mode and the action. A force strobe applies the action to the pin at once, without a real match.

Two sticky flags report events: an overflow flag that rises in the cycle the count wraps to zero, and a compare flag that rises on each real match. Each is cleared only by its own clear input, which models an interrupt acknowledge. All outputs are registered, and every write takes effect at the next clock edge.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count, the compare value, the mode, the action, the pin and both flags are all zero.
- R2: With any mode value other than 2, each cycle with tick high and no count write adds one to the count, and the count goes from 0xFF to 0x00. With tick low and no count write the count holds.
- R3: The overflow flag reads 1 from the edge at which a tick moves the count from 0xFF to 0x00. It then stays 1 until a cycle with ovf_clr high. If a wrap and ovf_clr fall in the same cycle, the flag is set.
- R4: A count write loads cnt_wdata at the next edge, overriding the tick. In that cycle no match is taken: no flag is set and the pin does not change.
- R5: With mode value 2, a tick while the count equals the compare value returns the count to 0. Any other tick adds one.
- R6: A match is a tick, with no count write, while the count equals the compare value, in either mode. A match sets the compare flag. The flag stays set until a cycle with cmp_clr high, and a match in that same cycle wins.
- R7: On a match the pin follows the action value: 00 leaves it unchanged, 01 toggles it, 10 drives it to 0 and 11 drives it to 1.
- R8: A new action value is applied from the first match after the cycle of its write. A match in the same cycle as the write still uses the previous value.
- R9: A force pulse applies the current action to the pin at the next edge. It does not set the compare flag and does not clear the count. A force in the same cycle as a match applies the action only once.
- R10: The action value never changes the count sequence. Only the mode, compare value and count writes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable pulse, one cycle per timer step |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Value loaded into the count |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 8 | New compare value |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Mode value (2 = clear-on-compare, others free-running) |
| act_we | input | 1 | Action write strobe |
| act_wdata | input | 2 | Action value (00 none, 01 toggle, 10 clear, 11 set) |
| force_pulse | input | 1 | Apply the action to the pin now |
| ovf_clr | input | 1 | Clear the overflow flag |
| cmp_clr | input | 1 | Clear the compare flag |
| pin | output | 1 | Waveform output level |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |
| count | output | 8 | Current count |

## Verification
The assertions take every input as a clean level sampled at the clock edge. They also assume tick and force_pulse are single-cycle strobes that may arrive in any combination with the write ports, since the block has no handshake. The stimulus draws every strobe independently from a seeded generator, so writes, forces and clears collide with ticks and matches. Small compare values are weighted in, so clear-on-compare periods close often. Directed runs place a wrap beside a clear, a write beside a match, and a force on a match.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } act_e;

  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_CLR_ON_MATCH = 3'd2;
endpackage

// File: rtl/tc_counter.sv
module tc_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] top_val,
  input  logic             clr_on_match,
  output logic [CNT_W-1:0] cnt,
  output logic             match_ev,
  output logic             wrap_ev
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic step;
  assign step     = tick && !ld;
  assign match_ev = step && (cnt == top_val);
  assign wrap_ev  = step && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ld) begin
      cnt <= ld_val;
    end else if (step) begin
      if (clr_on_match && (cnt == top_val)) cnt <= '0;
      else                                  cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tc_flag.sv
module tc_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/tc_wave.sv
module tc_wave
  import cmp_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       act_we,
  input  logic [1:0] act_wdata,
  input  logic       fire,
  output logic       pin
);
  act_e act_q;
  logic pin_nx;

  always_comb begin
    pin_nx = pin;
    case (act_q)
      ACT_TOGGLE: pin_nx = ~pin;
      ACT_CLEAR:  pin_nx = 1'b0;
      ACT_SET:    pin_nx = 1'b1;
      default:    pin_nx = pin;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= ACT_NONE;
      pin   <= 1'b0;
    end else begin
      if (act_we) act_q <= act_e'(act_wdata);
      if (fire)   pin   <= pin_nx;
    end
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              cmp_we,
  input  logic [CNT_W-1:0]  cmp_wdata,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              act_we,
  input  logic [1:0]        act_wdata,
  input  logic              force_pulse,
  input  logic              ovf_clr,
  input  logic              cmp_clr,
  output logic              pin,
  output logic              ovf_flag,
  output logic              cmp_flag,
  output logic [CNT_W-1:0]  count
);
  localparam int NFLAG = 2;

  logic [CNT_W-1:0]  cmp_q;
  logic [MODE_W-1:0] mode_q;
  logic              match_ev;
  logic              wrap_ev;
  logic [NFLAG-1:0]  flag_set;
  logic [NFLAG-1:0]  flag_clr;
  logic [NFLAG-1:0]  flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      mode_q <= '0;
    end else begin
      if (cmp_we)  cmp_q  <= cmp_wdata;
      if (mode_we) mode_q <= mode_wdata;
    end
  end

  tc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .ld(cnt_we), .ld_val(cnt_wdata),
    .top_val(cmp_q), .clr_on_match(mode_q == MODE_CLR_ON_MATCH),
    .cnt(count), .match_ev(match_ev), .wrap_ev(wrap_ev)
  );

  assign flag_set = {match_ev, wrap_ev};
  assign flag_clr = {cmp_clr, ovf_clr};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    tc_flag u_flag (
      .clk(clk), .rst(rst), .set(flag_set[i]), .clr(flag_clr[i]), .q(flag_q[i])
    );
  end

  assign ovf_flag = flag_q[0];
  assign cmp_flag = flag_q[1];

  tc_wave u_wave (
    .clk(clk), .rst(rst), .act_we(act_we), .act_wdata(act_wdata),
    .fire(match_ev || force_pulse), .pin(pin)
  );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             force_pulse,
  input logic             ovf_clr,
  input logic             cmp_clr,
  input logic             pin,
  input logic             ovf_flag,
  input logic             cmp_flag,
  input logic [CNT_W-1:0] count
);
  // R3: overflow flag is sticky until cleared
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !ovf_clr |=> ovf_flag);

  // R3: overflow flag rises only together with a zero count
  p_ovf_zero_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> (count == '0));

  // R4: a count write lands at the next edge
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (count == $past(cnt_wdata)));

  // R4: no match is taken in a write cycle
  p_load_nomatch_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_we && !force_pulse |=> $stable(pin));

  // R2: without tick or write the count holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick && !cnt_we |=> $stable(count));

  // R6: compare flag sticky until cleared
  p_cmp_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    cmp_flag && !cmp_clr |=> cmp_flag);

  // R9: force never sets the compare flag without a tick
  p_force_noflag_r9: assert property (@(posedge clk) disable iff (rst)
    !cmp_flag && (!tick || cnt_we) |=> !cmp_flag);
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
  .force_pulse(force_pulse), .ovf_clr(ovf_clr), .cmp_clr(cmp_clr),
  .pin(pin), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .count(count)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, cnt_we = 0, cmp_we = 0, mode_we = 0, act_we = 0;
  logic force_pulse = 0, ovf_clr = 0, cmp_clr = 0;
  logic [W-1:0] cnt_wdata = 0, cmp_wdata = 0;
  logic [2:0] mode_wdata = 0;
  logic [1:0] act_wdata = 0;
  logic pin, ovf_flag, cmp_flag;
  logic [W-1:0] count;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] m_cnt = 0, m_cmp = 0;
  logic [2:0] m_mode = 0;
  logic [1:0] m_act = 0;
  logic m_pin = 0, m_ovf = 0, m_cf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer u_cmp_timer (
    .clk(clk), .rst(rst), .tick(tick), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .act_we(act_we), .act_wdata(act_wdata), .force_pulse(force_pulse),
    .ovf_clr(ovf_clr), .cmp_clr(cmp_clr), .pin(pin), .ovf_flag(ovf_flag),
    .cmp_flag(cmp_flag), .count(count)
  );

  function automatic logic apply_act(input logic [1:0] a, input logic p);
    case (a)
      2'b01:   return ~p;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return p;
    endcase
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check({tag, " count (R2 R5 R10)"}, count, m_cnt);
    check({tag, " ovf_flag (R3)"}, ovf_flag, m_ovf);
    check({tag, " cmp_flag (R6)"}, cmp_flag, m_cf);
    check({tag, " pin (R7 R8 R9)"}, pin, m_pin);
  endtask

  // advance the model by the inputs currently driven, then one clock
  task automatic step(input string tag);
    logic match, wrap;
    match = tick && !cnt_we && (m_cnt == m_cmp);
    wrap  = tick && !cnt_we && (m_cnt == 8'hFF);
    if (match || force_pulse) m_pin = apply_act(m_act, m_pin);
    if (cnt_we) m_cnt = cnt_wdata;
    else if (tick) m_cnt = (m_mode == 3'd2 && match) ? 8'h00 : m_cnt + 8'h01;
    m_ovf = wrap  | (m_ovf & ~ovf_clr);
    m_cf  = match | (m_cf & ~cmp_clr);
    if (act_we)  m_act  = act_wdata;
    if (cmp_we)  m_cmp  = cmp_wdata;
    if (mode_we) m_mode = mode_wdata;
    @(negedge clk);
    compare_all(tag);
    tick = 0; cnt_we = 0; cmp_we = 0; mode_we = 0; act_we = 0;
    force_pulse = 0; ovf_clr = 0; cmp_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    compare_all("R1 reset");

    // R2/R3: wrap, with clear in the same cycle as the wrap
    cnt_we = 1; cnt_wdata = 8'hFE; step("R4 load");
    tick = 1; step("R2 inc");
    tick = 1; ovf_clr = 1; step("R3 wrap beats clear");
    ovf_clr = 1; step("R3 clear");
    tick = 0; step("R2 hold");

    // R5/R7: clear-on-compare with toggle
    cmp_we = 1; cmp_wdata = 8'd3; mode_we = 1; mode_wdata = 3'd2;
    act_we = 1; act_wdata = 2'b01; step("R5 setup");
    cnt_we = 1; cnt_wdata = 0; step("R4 load zero");
    for (int i = 0; i < 9; i++) begin tick = 1; step("R5 R7 period"); end

    // R8: write on the match cycle does not affect that match
    cnt_we = 1; cnt_wdata = 8'd3; step("R4 load top");
    tick = 1; act_we = 1; act_wdata = 2'b11; step("R8 same-cycle write");
    cnt_we = 1; cnt_wdata = 8'd3; step("R4 reload");
    tick = 1; step("R8 new action at match");

    // R4: write blocks a match
    cnt_we = 1; cnt_wdata = 8'd3; act_we = 1; act_wdata = 2'b01; step("R4 prep");
    tick = 1; cnt_we = 1; cnt_wdata = 8'd3; cmp_clr = 1; step("R4 no match on write");

    // R9: force alone, and force on a match
    cnt_we = 1; cnt_wdata = 8'd1; step("R9 prep");
    force_pulse = 1; step("R9 force");
    force_pulse = 1; act_we = 1; act_wdata = 2'b10; step("R9 force old action");
    cnt_we = 1; cnt_wdata = 8'd3; act_we = 1; act_wdata = 2'b01; step("R9 prep2");
    tick = 1; force_pulse = 1; step("R9 force on match once");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      tick        = ($urandom % 10) < 7;
      cnt_we      = ($urandom % 40) == 0;
      cnt_wdata   = ($urandom % 4 == 0) ? 8'hFD + 8'($urandom % 3) : 8'($urandom);
      cmp_we      = ($urandom % 40) == 0;
      cmp_wdata   = ($urandom % 2) ? 8'($urandom % 8) : 8'($urandom);
      mode_we     = ($urandom % 60) == 0;
      mode_wdata  = ($urandom % 2) ? 3'd2 : 3'($urandom);
      act_we      = ($urandom % 20) == 0;
      act_wdata   = 2'($urandom);
      force_pulse = ($urandom % 30) == 0;
      ovf_clr     = ($urandom % 10) == 0;
      cmp_clr     = ($urandom % 10) == 0;
      step("R2 R5 R6 R7 R10 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule